// File: doc/BRIEF.md
# Reset Cause Capture Register

This block is a single 32-bit status and control register that remembers which events caused the resets seen since the flags were last cleared. Eight reset sources each drive a one-cycle strobe: low-power entry, window watchdog, free-running watchdog, software request, power-on, external reset pin, option-byte reload and core-supply monitor. Each strobe sets its own sticky flag. The flags survive a system reset. Only a power-on reset, or software writing 1 to a dedicated clear bit, removes them.

The same word also holds an enable bit for the 40 kHz low-speed internal oscillator. Beside it is a read-only stable bit, which follows the oscillator's ready signal through a synchronizer. Unlike the flags, the enable bit returns to 0 on every system reset. The register has one address, so the bus port has a write strobe, four byte-lane enables, write data and a combinational read-data output.

Top module: `rstcause_reg`

## Requirements
- R1: After power-on reset the register reads 0x0C00_0000: the power-on flag (bit 27) and the pin flag (bit 26) are set and the oscillator enable is 0.
- R2: Event strobe `evt_i[k]` sets one flag on the next clock edge, at bit 31 for k=7 (low-power), 30 for k=6 (window watchdog), 29 for k=5 (free watchdog), 28 for k=4 (software), 27 for k=3 (power-on), 26 for k=2 (pin), 25 for k=1 (option-byte) and 23 for k=0 (core supply). Strobes that arrive together or one after another accumulate.
- R3: A write with byte lane 3 enabled and data bit 24 at 1 clears every flag on that clock edge. Bit 24 always reads 0.
- R4: If an event strobe arrives in the same cycle as a clearing write, the event's flag ends up set.
- R5: Writing the flag bit positions never sets or clears a flag. Only the clear bit changes them.
- R6: A system reset without a power-on reset leaves every flag unchanged and returns the oscillator enable to 0.
- R7: Bit 0 (oscillator enable) is written only when byte lane 0 is enabled. Bit 24 acts only when byte lane 3 is enabled.
- R8: Bit 1 (oscillator stable) shows `osc_rdy_i` after two clock edges of synchronization, and reads 0 whenever the enable bit is 0.
- R9: Bits 2 to 22 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; resets everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; spares the flags |
| evt_i | input | 8 | One-cycle reset-event strobes, one per source |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| osc_rdy_i | input | 1 | Oscillator ready, asynchronous |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench builds the block with its default parameters: eight sources, a 32-bit word and a two-stage synchronizer. With eight sources, all 256 event patterns can be swept, and each pattern is checked after a clear and again combined with a second pattern. All sixteen byte-enable combinations are swept with all-ones data. The two-stage synchronizer keeps the stable-bit latency short enough to sample edge by edge. Sticky behaviour across a system reset and the event-versus-clear collision are checked at the read port.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
   localparam int WORD_W   = 32;
   localparam int NSRC     = 8;
   localparam int CLR_BIT  = 24;
   localparam int CORE_BIT = 23;
   localparam int EN_BIT   = 0;
   localparam int STB_BIT  = 1;

   // bit position of the flag for source k
   function automatic int flag_bit(input int k);
      return (k == 0) ? CORE_BIT : CLR_BIT + k;
   endfunction
endpackage

// File: rtl/rc_flag_bank.sv
module rc_flag_bank #(
   parameter int               N         = 8,
   parameter logic [N-1:0]     POR_VALUE = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         clr_i,
   input  logic [N-1:0] evt_i,
   output logic [N-1:0] flags_o
);
   logic [N-1:0] q;

   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)        q[k] <= POR_VALUE[k];
         else if (evt_i[k]) q[k] <= 1'b1;
         else if (clr_i)    q[k] <= 1'b0;
      end
   end

   assign flags_o = q;

   p_clear_r3: assert property (@(posedge clk) disable iff (!por_n)
      (clr_i && evt_i == '0) |=> (flags_o == '0));
   p_event_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
      (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
   p_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!clr_i && evt_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/rc_osc_ctrl.sv
module rc_osc_ctrl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_we,
   input  logic en_d,
   input  logic rdy_async,
   output logic en_o,
   output logic stable_o
);
   logic en_q;
   logic rdy_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_we) en_q <= en_d;
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rdy_s = rdy_async;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0], rdy_async};
      end
      assign rdy_s = chain[SYNC_STAGES-1];
   end

   assign en_o     = en_q;
   assign stable_o = en_q & rdy_s;

   p_stable_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_o |-> !stable_o);
   p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(en_o));
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
   import rstcause_pkg::*;
#(
   parameter int              DATA_W      = WORD_W,
   parameter int              NUM_SRC     = NSRC,
   parameter int              SYNC_STAGES = 2,
   parameter logic [NUM_SRC-1:0] POR_FLAGS = 8'b0000_1100
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                sys_rst_n,
   input  logic [NUM_SRC-1:0]  evt_i,
   input  logic                wr_en,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                osc_rdy_i,
   output logic                osc_en_o
);
   localparam int NBYTE    = DATA_W / 8;
   localparam int CLR_LANE = CLR_BIT / 8;
   localparam int EN_LANE  = EN_BIT / 8;

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("rstcause_reg: DATA_W must be %0d", WORD_W);
   end
   if (NUM_SRC != NSRC) begin : g_bad_src
      $error("rstcause_reg: NUM_SRC must be %0d", NSRC);
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("rstcause_reg: SYNC_STAGES out of range");
   end

   logic               sys_n;
   logic               clr;
   logic               stable;
   logic [NUM_SRC-1:0] flags;
   logic               unused_wr;

   assign sys_n = por_n & sys_rst_n;
   assign clr   = wr_en & wr_be[CLR_LANE] & wr_data[CLR_BIT];
   assign unused_wr = ^{wr_data[DATA_W-1:CLR_BIT+1], wr_data[CLR_BIT-1:EN_BIT+1],
                        wr_be[NBYTE-2:EN_LANE+1]};

   rc_flag_bank #(.N(NUM_SRC), .POR_VALUE(POR_FLAGS)) u_flags (
      .clk    (clk),
      .por_n  (por_n),
      .clr_i  (clr),
      .evt_i  (evt_i),
      .flags_o(flags)
   );

   rc_osc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_osc (
      .clk      (clk),
      .rst_n    (sys_n),
      .en_we    (wr_en & wr_be[EN_LANE]),
      .en_d     (wr_data[EN_BIT]),
      .rdy_async(osc_rdy_i),
      .en_o     (osc_en_o),
      .stable_o (stable)
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_SRC; k++) rd_data[flag_bit(k)] = flags[k];
      rd_data[EN_BIT]  = osc_en_o;
      rd_data[STB_BIT] = stable;
   end

   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
      rd_data[CORE_BIT-1:STB_BIT+1] == '0);
   p_clr_reads_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
      !rd_data[CLR_BIT]);
   p_sticky_sysrst_r6: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && evt_i == '0) |=> $stable(flags));
   p_event_wins_r4: assert property (@(posedge clk) disable iff (!por_n)
      (clr && evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));
endmodule

// File: tb/sim_rstcause_reg.sv
module sim_rstcause_reg;
   logic        clk = 0;
   logic        por_n = 0, sys_rst_n = 1;
   logic [7:0]  evt = 0;
   logic        wr_en = 0;
   logic [3:0]  wr_be = 0;
   logic [31:0] wr_data = 0;
   logic [31:0] rd_data;
   logic        osc_rdy = 0, osc_en;
   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rstcause_reg u0 (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .evt_i(evt),
      .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
      .osc_rdy_i(osc_rdy), .osc_en_o(osc_en));

   function automatic logic [31:0] map(input logic [7:0] p);
      logic [31:0] r = 0;
      for (int k = 0; k < 8; k++) r[(k == 0) ? 23 : 24 + k] = p[k];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(); @(posedge clk); @(negedge clk); endtask

   task automatic wr(input logic [3:0] be, input logic [31:0] d);
      wr_en = 1; wr_be = be; wr_data = d; step(); wr_en = 0; wr_be = 0; wr_data = 0;
   endtask

   task automatic pulse(input logic [7:0] p);
      evt = p; step(); evt = 0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk); por_n = 1; @(negedge clk);
      chk("R1 por value", rd_data, 32'h0C00_0000);
      chk("R1 osc_en", {31'b0, osc_en}, 0);

      for (int p = 0; p < 256; p++) begin
         wr(4'b1000, 32'h0100_0000);
         chk("R3 cleared", rd_data, 0);
         pulse(p[7:0]);
         chk("R2 single pattern", rd_data, map(p[7:0]));
         pulse({p[0], p[7:1]} ^ 8'h5A);
         chk("R2 accumulate", rd_data, map(p[7:0] | ({p[0], p[7:1]} ^ 8'h5A)));
         chk("R9 reserved", rd_data & 32'h007F_FFFC, 0);
      end

      wr(4'b1000, 32'h0100_0000);
      evt = 8'h81; wr(4'b1000, 32'h0100_0000); evt = 0;
      chk("R4 event wins", rd_data, map(8'h81));

      pulse(8'h22);
      wr(4'b1111, 32'hFE80_0000);
      chk("R5 flags not writable", rd_data, map(8'hA3));
      wr(4'b1111, 32'h0000_0000);
      chk("R5 zero write keeps flags", rd_data, map(8'hA3));
      wr(4'b1111, 32'h007F_FFFC);
      chk("R9 reserved ignore writes", rd_data, map(8'hA3));

      wr(4'b0001, 32'h1);
      chk("R7 enable set", rd_data, map(8'hA3) | 1);
      sys_rst_n = 0; @(negedge clk); sys_rst_n = 1; @(negedge clk);
      chk("R6 flags sticky", rd_data, map(8'hA3));
      chk("R6 enable reset", {31'b0, osc_en}, 0);

      for (int be = 0; be < 16; be++) begin
         pulse(8'hFF);
         wr(4'b0001, 32'h0);
         wr(be[3:0], 32'hFFFF_FFFF);
         chk("R7 byte lanes", rd_data, (be[3] ? 32'h0 : map(8'hFF)) | {31'b0, be[0]});
      end

      wr(4'b0001, 32'h1);
      osc_rdy = 1; step();
      chk("R8 one edge", rd_data & 2, 0);
      step();
      chk("R8 two edges", rd_data & 2, 2);
      wr(4'b0001, 32'h0);
      chk("R8 gated by enable", rd_data & 2, 0);
      wr(4'b0001, 32'h1);
      chk("R8 re-enabled", rd_data & 2, 2);
      osc_rdy = 0; step();
      chk("R8 falling one edge", rd_data & 2, 2);
      step();
      chk("R8 falling two edges", rd_data & 2, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule